// File: doc/BRIEF.md
# Graphics Aperture Address Remapper

This block sits on the request path of a graphics master and rewrites 32-bit physical addresses. One programmable window of the address space is the aperture. A request whose address falls inside it is translated page by page: the block reads one 32-bit entry from a translation table in memory, takes the page frame from the entry and keeps the 12-bit offset within the 4 KB page. This lets the master see a contiguous region that is in fact spread over scattered system-memory pages. Requests outside the window leave unchanged. A trap control can instead reject them with an error response. The trap is off after reset.

The table entry for a hit lives at `table base + ((address - aperture base) >> 12) * 4`. The block holds no cached entries, so it fetches the table on every aperture hit. Only one fetch is in flight at a time. The request input drops its ready signal from the cycle after a hit is accepted until that request's result is produced.

Top module: `gfx_aperture_remap`

## Requirements
- R1: After reset, `req_ready` is 1, `out_valid` is 0, `tbl_rd` is 0 and trapping is disabled.
- R2: A request whose address is outside the window, accepted while trapping is disabled, gives `out_valid`=1 in the next cycle with `out_addr` equal to the request address, `out_err`=0 and `out_remap`=0. No table read is issued.
- R3: A request inside the window raises `tbl_rd` for exactly one cycle, in the cycle after acceptance. `tbl_rd_addr` = `cfg_tbl_base + ((req_addr - cfg_ap_base) >> 12) * 4`.
- R4: The cycle after `tbl_rvalid`, if entry bit 0 is 1, gives `out_valid`=1, `out_remap`=1, `out_err`=0 and `out_addr` = {entry[31:12], req_addr[11:0]}. Entry bits 11:1 are ignored.
- R5: If entry bit 0 is 0, the response is `out_valid`=1, `out_err`=1, `out_remap`=0 and `out_addr`=0.
- R6: `req_ready` is 0 from the cycle after an in-window request is accepted until the cycle its response is valid. Only one table read is outstanding at a time.
- R7: While trapping is enabled, an out-of-window request gives `out_valid`=1, `out_err`=1 and `out_addr`=0 in the next cycle, and issues no table read.
- R8: A cycle with `trap_we`=1 loads `trap_wdata` into the trap control. The control takes effect for requests accepted after that cycle. Writing 0 restores pass-through.
- R9: The window covers the `2^cfg_ap_lg2` bytes starting at `cfg_ap_base`. `cfg_ap_lg2` must be in 12..31 and the base must be aligned to the size. The address base-1 and base+size are outside the window, and base+size-1 is inside.
- R10: Each accepted request produces exactly one cycle of `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Request physical address |
| out_valid | output | 1 | Result valid for one cycle |
| out_addr | output | 32 | Translated or pass-through address (0 on error) |
| out_err | output | 1 | Request rejected (trap or invalid entry) |
| out_remap | output | 1 | Address came from a table entry |
| tbl_rd | output | 1 | Table read strobe |
| tbl_rd_addr | output | 32 | Table entry address |
| tbl_rvalid | input | 1 | Table read data present |
| tbl_rdata | input | 32 | Table entry: [31:12] frame, [0] valid |
| cfg_ap_base | input | 32 | Aperture base, aligned to the size |
| cfg_ap_lg2 | input | 5 | log2 of the aperture size in bytes (12..31) |
| cfg_tbl_base | input | 32 | Translation table base, 4-byte aligned |
| trap_we | input | 1 | Write strobe for the trap control |
| trap_wdata | input | 1 | New trap control value |

## Verification
Random addresses are drawn half from inside the current window and half from the whole 32-bit space. This separates the hit path from the pass-through path and checks that the index arithmetic holds for many aperture sizes, bases and table bases. The table model returns entries with both valid and clear bit 0 and with junk in bits 11:1, so a run shows whether the frame is spliced correctly and whether invalid entries become errors. The memory latency varies between 1 and 4 cycles, which shows that the response follows the returned data and not a fixed delay. Directed cases probe the three addresses at the window edges and switch the trap control on and off between requests.

// File: rtl/gar_pkg.sv
package gar_pkg;
  localparam int ADDR_W   = 32;
  localparam int PAGE_LG2 = 12;
  localparam int ENT_LG2  = 2;
  localparam int SZ_W     = $clog2(ADDR_W);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [SZ_W-1:0]   lg2_t;

  typedef enum logic [1:0] {W_IDLE, W_ISSUE, W_WAIT} walk_st_t;

  localparam addr_t OFF_MASK = (addr_t'(1) << PAGE_LG2) - addr_t'(1);

  function automatic addr_t win_mask(lg2_t lg2);
    return ~((addr_t'(1) << lg2) - addr_t'(1));
  endfunction

  function automatic logic win_hit(addr_t a, addr_t base, lg2_t lg2);
    return ((a ^ base) & win_mask(lg2)) == '0;
  endfunction

  function automatic addr_t entry_addr(addr_t a, addr_t base, addr_t tbl);
    return tbl + (((a - base) >> PAGE_LG2) << ENT_LG2);
  endfunction

  function automatic addr_t splice(addr_t entry, addr_t a);
    return (entry & ~OFF_MASK) | (a & OFF_MASK);
  endfunction
endpackage

// File: rtl/gar_window.sv
module gar_window
  import gar_pkg::*;
(
  input  addr_t addr,
  input  addr_t ap_base,
  input  lg2_t  ap_lg2,
  input  addr_t tbl_base,
  output logic  hit,
  output addr_t ent_addr
);
  always_comb begin
    hit      = win_hit(addr, ap_base, ap_lg2);
    ent_addr = entry_addr(addr, ap_base, tbl_base);
  end
endmodule

// File: rtl/gar_trap_reg.sv
module gar_trap_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wdata,
  output logic en
);
  always_ff @(posedge clk) begin
    if (!rst_n)  en <= 1'b0;
    else if (we) en <= wdata;
  end
endmodule

// File: rtl/gar_walker.sv
module gar_walker
  import gar_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  addr_t start_addr,
  input  addr_t start_ent,
  output logic  busy,
  output logic  tbl_rd,
  output addr_t tbl_rd_addr,
  input  logic  tbl_rvalid,
  input  addr_t tbl_rdata,
  output logic  done,
  output addr_t done_addr,
  output logic  done_err
);
  walk_st_t st;
  addr_t    held_addr;
  addr_t    held_ent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= W_IDLE;
      held_addr <= '0;
      held_ent  <= '0;
    end else begin
      unique case (st)
        W_IDLE:  if (start) begin
                   st        <= W_ISSUE;
                   held_addr <= start_addr;
                   held_ent  <= start_ent;
                 end
        W_ISSUE: st <= W_WAIT;
        W_WAIT:  if (tbl_rvalid) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    busy        = (st != W_IDLE);
    tbl_rd      = (st == W_ISSUE);
    tbl_rd_addr = held_ent;
    done        = (st == W_WAIT) && tbl_rvalid;
    done_addr   = splice(tbl_rdata, held_addr);
    done_err    = ~tbl_rdata[0];
  end
endmodule

// File: rtl/gfx_aperture_remap.sv
module gfx_aperture_remap
  import gar_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        out_valid,
  output logic [31:0] out_addr,
  output logic        out_err,
  output logic        out_remap,
  output logic        tbl_rd,
  output logic [31:0] tbl_rd_addr,
  input  logic        tbl_rvalid,
  input  logic [31:0] tbl_rdata,
  input  logic [31:0] cfg_ap_base,
  input  logic [4:0]  cfg_ap_lg2,
  input  logic [31:0] cfg_tbl_base,
  input  logic        trap_we,
  input  logic        trap_wdata
);
  logic  win_hit_w;
  addr_t ent_addr_w;
  logic  trap_en;
  logic  busy;
  logic  walk_done;
  addr_t walk_addr;
  logic  walk_err;
  logic  accept, walk_start, pass_evt, trap_evt;

  gar_window u_win (
    .addr(req_addr), .ap_base(cfg_ap_base), .ap_lg2(cfg_ap_lg2),
    .tbl_base(cfg_tbl_base), .hit(win_hit_w), .ent_addr(ent_addr_w)
  );

  gar_trap_reg u_trap (
    .clk(clk), .rst_n(rst_n), .we(trap_we), .wdata(trap_wdata), .en(trap_en)
  );

  gar_walker u_walk (
    .clk(clk), .rst_n(rst_n), .start(walk_start), .start_addr(req_addr),
    .start_ent(ent_addr_w), .busy(busy), .tbl_rd(tbl_rd),
    .tbl_rd_addr(tbl_rd_addr), .tbl_rvalid(tbl_rvalid), .tbl_rdata(tbl_rdata),
    .done(walk_done), .done_addr(walk_addr), .done_err(walk_err)
  );

  always_comb begin
    req_ready  = ~busy;
    accept     = req_valid && req_ready;
    walk_start = accept && win_hit_w;
    pass_evt   = accept && !win_hit_w && !trap_en;
    trap_evt   = accept && !win_hit_w && trap_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_err   <= 1'b0;
      out_remap <= 1'b0;
    end else begin
      out_valid <= walk_done || pass_evt || trap_evt;
      if (walk_done) begin
        out_err   <= walk_err;
        out_remap <= ~walk_err;
        out_addr  <= walk_err ? '0 : walk_addr;
      end else if (pass_evt) begin
        out_err   <= 1'b0;
        out_remap <= 1'b0;
        out_addr  <= req_addr;
      end else if (trap_evt) begin
        out_err   <= 1'b1;
        out_remap <= 1'b0;
        out_addr  <= '0;
      end
    end
  end
endmodule

// File: rtl/gar_checker.sv
module gar_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        out_valid,
  input logic [31:0] out_addr,
  input logic        out_err,
  input logic        out_remap,
  input logic        tbl_rd,
  input logic        hit,
  input logic        trap_en,
  input logic        walk_done
);
  AST_FETCH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd |-> !req_ready); // R6
  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd |=> !tbl_rd); // R3
  AST_HIT_FETCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && hit) |=> tbl_rd); // R3
  AST_PASS_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !hit && !trap_en) |=>
      (out_valid && !out_err && !out_remap && out_addr == $past(req_addr))); // R2
  AST_TRAP_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !hit && trap_en) |=>
      (out_valid && out_err && !tbl_rd)); // R7
  AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_addr == 32'h0 && !out_remap)); // R5
  AST_DATA_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> out_valid); // R4
endmodule

bind gfx_aperture_remap gar_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .out_valid(out_valid), .out_addr(out_addr),
  .out_err(out_err), .out_remap(out_remap), .tbl_rd(tbl_rd),
  .hit(win_hit_w), .trap_en(trap_en), .walk_done(walk_done)
);

// File: tb/sim_gfx_aperture_remap.sv
module sim_gfx_aperture_remap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_err;
  logic        out_remap;
  logic        tbl_rd;
  logic [31:0] tbl_rd_addr;
  logic        tbl_rvalid = 1'b0;
  logic [31:0] tbl_rdata = '0;
  logic [31:0] ap_base = 32'h4000_0000;
  logic [4:0]  ap_lg2 = 5'd16;
  logic [31:0] tbl_base = 32'h0010_0000;
  logic        trap_we = 1'b0;
  logic        trap_wdata = 1'b0;
  bit          trap_model = 1'b0;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  gfx_aperture_remap u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .out_valid(out_valid), .out_addr(out_addr),
    .out_err(out_err), .out_remap(out_remap), .tbl_rd(tbl_rd),
    .tbl_rd_addr(tbl_rd_addr), .tbl_rvalid(tbl_rvalid), .tbl_rdata(tbl_rdata),
    .cfg_ap_base(ap_base), .cfg_ap_lg2(ap_lg2), .cfg_tbl_base(tbl_base),
    .trap_we(trap_we), .trap_wdata(trap_wdata)
  );

  function automatic logic [31:0] tbl_word(logic [31:0] idx);
    logic [19:0] frame;
    frame = 20'(idx * 32'h2F1B + 32'h155);
    return {frame, 11'h3A5, ((idx % 5) != 2)};
  endfunction

  function automatic bit in_win(logic [31:0] a);
    return ((a ^ ap_base) >> ap_lg2) == 32'h0;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_trap(bit v);
    @(negedge clk);
    trap_we = 1'b1; trap_wdata = v;
    @(negedge clk);
    trap_we = 1'b0;
    trap_model = v;
  endtask

  task automatic do_req(logic [31:0] a, int lat);
    logic [31:0] idx, word, exp_a;
    @(negedge clk);
    chk(req_ready === 1'b1, "R6 ready before request", 32'(req_ready), 1);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (in_win(a)) begin
      idx = (a - ap_base) / 4096;
      chk(tbl_rd === 1'b1 && tbl_rd_addr === tbl_base + idx * 4,
          "R3 table read", tbl_rd_addr, tbl_base + idx * 4);
      chk(out_valid === 1'b0, "R10 no early result", 32'(out_valid), 0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(tbl_rd === 1'b0 && req_ready === 1'b0, "R6 stall during walk",
            {30'h0, tbl_rd, req_ready}, 0);
      end
      word = tbl_word((tbl_rd_addr - tbl_base) >> 2);
      tbl_rvalid = 1'b1; tbl_rdata = word;
      @(negedge clk);
      tbl_rvalid = 1'b0; tbl_rdata = 32'hDEAD_BEEF;
      if (word[0]) begin
        exp_a = {word[31:12], a[11:0]};
        chk(out_valid === 1'b1 && out_err === 1'b0 && out_remap === 1'b1 && out_addr === exp_a,
            "R4 translated address", out_addr, exp_a);
      end else begin
        chk(out_valid === 1'b1 && out_err === 1'b1 && out_remap === 1'b0 && out_addr === 32'h0,
            "R5 invalid entry error", {out_err, out_addr[30:0]}, 32'h8000_0000);
      end
    end else if (trap_model) begin
      chk(tbl_rd === 1'b0 && out_valid === 1'b1 && out_err === 1'b1 && out_addr === 32'h0,
          "R7 trapped request", {out_err, out_addr[30:0]}, 32'h8000_0000);
    end else begin
      chk(tbl_rd === 1'b0 && out_valid === 1'b1 && out_err === 1'b0 &&
          out_remap === 1'b0 && out_addr === a, "R2 pass-through", out_addr, a);
    end
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 single result cycle", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && out_valid === 1'b0 && tbl_rd === 1'b0, "R1 reset state",
        {29'h0, req_ready, out_valid, tbl_rd}, 32'h4);
    // R1, R8: trap disabled after reset, so out-of-window passes
    do_req(32'h1234_5678, 1);
    // R9: window edges
    do_req(ap_base - 1, 1);
    do_req(ap_base, 2);
    do_req(ap_base + (32'h1 << ap_lg2) - 1, 3);
    do_req(ap_base + (32'h1 << ap_lg2), 1);
    // R8, R7: enable then disable trap
    set_trap(1'b1);
    do_req(32'h8000_0004, 1);
    do_req(ap_base + 32'h3ABC, 1);
    set_trap(1'b0);
    do_req(32'h8000_0004, 1);
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      if (n % 40 == 0) begin
        ap_lg2   = 5'(12 + $urandom_range(0, 8));
        ap_base  = $urandom() & ~((32'h1 << ap_lg2) - 1);
        tbl_base = $urandom() & 32'hFFFF_FFFC;
        set_trap(($urandom() % 3) == 0);
      end
      if ($urandom() % 2 == 0)
        a = ap_base | ($urandom() & ((32'h1 << ap_lg2) - 1));
      else
        a = $urandom();
      do_req(a, int'($urandom_range(1, 4)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule